// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides, one access at a time, whether a processor is allowed to touch a memory address. Software sets up a small table of protection regions through a word-wide register port. Each region has five parts. The first is a base address. The second is a power-of-two size. The third is eight bits that each remove one eighth of the region. The fourth is four permission bits, which separate privileged from unprivileged access and read from write. The fifth is an execute-never flag, plus a group of memory attribute bits.

For each request the block looks at the address, the direction, the privilege level and whether the access is an instruction fetch. It looks up every region in parallel. When regions overlap, the highest-numbered region that matches wins. The block then returns allow or deny, whether a region matched, which region it was, and that region's attribute bits. The answer is registered and appears one clock after the request.

An access that matches no region is handled as follows:
- An unprivileged access is refused.
- A privileged access is allowed only when the background bit is set.
- A global enable of 0 lets every access through with the default attribute value.

The first refused access is recorded in two status words and held there until software clears it.

Top module: `mem_guard`

## Requirements
- R1: After reset the response outputs are 0. The control word (register index 0) reads 0, and the fault-info word (index 2) reads 0.
- R2: A request sampled at a rising edge produces `resp_valid` = 1 after that edge, together with its result. With no request, `resp_valid` is 0 after the edge.
- R3: A region's size code s in bits [4:0] of its config word (index 17+2n) gives a size of 2^(s+1) bytes. Codes below 4 count as 4, so sizes run from 32 bytes to 4 GB. An address matches when it agrees with the base word (index 16+2n) above bit s. Bit 0 of the base word enables the region.
- R4: Config bits [15:8] exclude sub-regions. Bit 8+k, when set, removes the k-th eighth of the region, counting from its lowest address, and an access there does not match that region.
- R5: When several enabled regions match, the highest-numbered one decides the result. `resp_region` reports that region's number and `resp_hit` is 1.
- R6: Config bits [19:16] are permissions, from bit 16 upward: privileged read, privileged write, unprivileged read, unprivileged write. An access is allowed only if the bit for its privilege and direction is set.
- R7: Config bit 20 is execute-never. A fetch is checked against the read permission, and it is refused whenever the winning region has execute-never set.
- R8: With protection on and no region matching, the result depends on the access. An unprivileged access is refused. A privileged access is allowed only when control bit 1 (background) is set. Either way `resp_hit` is 0 and `resp_attr` is the default value 6'h01.
- R9: With control bit 0 (global enable) at 0, every access is allowed, with `resp_hit` = 0 and `resp_attr` = 6'h01.
- R10: On a match, `resp_attr` carries config bits [29:24] of the winning region.
- R11: The first refused access stores its address in index 1. It also sets index 2 to {fetch, privileged, write, valid} in bits [3:0]. Later refusals leave both words unchanged. Writing 1 to bit 0 of index 2 clears both words.
- R12: The control, base and config words read back what was written, one clock after the read index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged access |
| req_fetch | input | 1 | 1 = instruction fetch |
| resp_valid | output | 1 | Result of the previous cycle's request |
| resp_allow | output | 1 | Access allowed |
| resp_hit | output | 1 | An enabled region matched |
| resp_region | output | 3 | Number of the winning region |
| resp_attr | output | 6 | Attribute bits of the winning region, or the default |

## Verification
Some behaviour is checked by properties on every cycle:
- the one-cycle response timing;
- that all accesses pass while the global enable is off;
- that an unprivileged miss is never allowed;
- that every refused response coincides with a captured fault, which then stays frozen until a clear.

Other behaviour only the directed scenarios can show, because each case needs a specific address against a specific table:
- region sizing, including the 32-byte and 4 GB ends;
- sub-region holes;
- priority between overlapping regions;
- the permission and execute-never combinations;
- attribute selection;
- the exact contents of the fault words.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int REG_CTRL     = 0;
  localparam int REG_FADDR    = 1;
  localparam int REG_FINFO    = 2;
  localparam int REG_RGN_BASE = 16;

  localparam int F_SRD_LO  = 8;
  localparam int F_PERM_LO = 16;
  localparam int F_XN      = 20;
  localparam int F_ATTR_LO = 24;
  localparam int MIN_SZ    = 4;

  typedef struct packed {
    logic uw;
    logic ur;
    logic pw;
    logic pr;
  } perm_t;
endpackage

// File: rtl/mg_regs.sv
module mg_regs
  import mg_pkg::*;
#(
  parameter int N_RGN  = 8,
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_wr,
  input  logic [CFG_AW-1:0]                 cfg_addr,
  input  logic [ADDR_W-1:0]                 cfg_wdata,
  output logic [ADDR_W-1:0]                 cfg_rdata,
  output logic                              glob_en,
  output logic                              bg_en,
  output logic [N_RGN-1:0][ADDR_W-1:0]      rgn_base,
  output logic [N_RGN-1:0][ADDR_W-1:0]      rgn_cfg,
  input  logic                              deny_evt,
  input  logic [ADDR_W-1:0]                 deny_addr,
  input  logic                              deny_write,
  input  logic                              deny_priv,
  input  logic                              deny_fetch,
  output logic                              fault_clr,
  output logic                              fault_valid,
  output logic [ADDR_W-1:0]                 fault_addr
);
  logic [1:0]  ctrl_q;
  logic [2:0]  finfo_q;
  logic        capture;
  logic [ADDR_W-1:0] rd_mux;

  assign glob_en   = ctrl_q[0];
  assign bg_en     = ctrl_q[1];
  assign fault_clr = cfg_wr && (cfg_addr == CFG_AW'(REG_FINFO)) && cfg_wdata[0];
  assign capture   = deny_evt && (!fault_valid || fault_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      for (int i = 0; i < N_RGN; i++) begin
        rgn_base[i] <= '0;
        rgn_cfg[i]  <= '0;
      end
    end else if (cfg_wr) begin
      if (cfg_addr == CFG_AW'(REG_CTRL)) ctrl_q <= cfg_wdata[1:0];
      for (int i = 0; i < N_RGN; i++) begin
        if (cfg_addr == CFG_AW'(REG_RGN_BASE + 2*i))     rgn_base[i] <= cfg_wdata;
        if (cfg_addr == CFG_AW'(REG_RGN_BASE + 2*i + 1)) rgn_cfg[i]  <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_valid <= 1'b0;
      fault_addr  <= '0;
      finfo_q     <= '0;
    end else if (capture) begin
      fault_valid <= 1'b1;
      fault_addr  <= deny_addr;
      finfo_q     <= {deny_fetch, deny_priv, deny_write};
    end else if (fault_clr) begin
      fault_valid <= 1'b0;
      fault_addr  <= '0;
      finfo_q     <= '0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (cfg_addr == CFG_AW'(REG_CTRL))  rd_mux = ADDR_W'(ctrl_q);
    if (cfg_addr == CFG_AW'(REG_FADDR)) rd_mux = fault_addr;
    if (cfg_addr == CFG_AW'(REG_FINFO)) rd_mux = ADDR_W'({finfo_q, fault_valid});
    for (int i = 0; i < N_RGN; i++) begin
      if (cfg_addr == CFG_AW'(REG_RGN_BASE + 2*i))     rd_mux = rgn_base[i];
      if (cfg_addr == CFG_AW'(REG_RGN_BASE + 2*i + 1)) rd_mux = rgn_cfg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/mg_region.sv
module mg_region
  import mg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 6
) (
  input  logic [ADDR_W-1:0] base_w,
  input  logic [ADDR_W-1:0] cfg_w,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output perm_t             perm,
  output logic              xn,
  output logic [ATTR_W-1:0] attr
);
  localparam int SZ_W = $clog2(ADDR_W);

  logic [SZ_W-1:0]   code;
  logic [SZ_W-1:0]   sz;
  logic [SZ_W:0]     shamt;
  logic [ADDR_W:0]   span;
  logic [ADDR_W:0]   span_m1;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] sub_sh;
  logic [2:0]        sub_idx;
  logic [7:0]        srd;
  logic              in_range;

  assign code    = cfg_w[SZ_W-1:0];
  assign sz      = (code < SZ_W'(MIN_SZ)) ? SZ_W'(MIN_SZ) : code;
  assign shamt   = {1'b0, sz} + 1'b1;
  assign span    = (ADDR_W+1)'(1) << shamt;
  assign span_m1 = span - 1'b1;
  assign mask    = ~span_m1[ADDR_W-1:0];
  assign in_range = ((addr ^ base_w) & mask) == '0;
  assign sub_sh  = addr >> (sz - SZ_W'(2));
  assign sub_idx = sub_sh[2:0];
  assign srd     = cfg_w[F_SRD_LO +: 8];

  assign hit  = base_w[0] && in_range && !srd[sub_idx];
  assign perm = cfg_w[F_PERM_LO +: 4];
  assign xn   = cfg_w[F_XN];
  assign attr = cfg_w[F_ATTR_LO +: ATTR_W];
endmodule

// File: rtl/mg_decide.sv
module mg_decide
  import mg_pkg::*;
#(
  parameter int N_RGN  = 8,
  parameter int ATTR_W = 6,
  parameter logic [ATTR_W-1:0] DEFAULT_ATTR = 6'h01,
  localparam int IDX_W = (N_RGN > 1) ? $clog2(N_RGN) : 1
) (
  input  logic [N_RGN-1:0]             hit,
  input  perm_t [N_RGN-1:0]            perm,
  input  logic [N_RGN-1:0]             xn,
  input  logic [N_RGN-1:0][ATTR_W-1:0] attr,
  input  logic                         glob_en,
  input  logic                         bg_en,
  input  logic                         is_write,
  input  logic                         is_priv,
  input  logic                         is_fetch,
  output logic                         allow,
  output logic                         any_hit,
  output logic [IDX_W-1:0]             win,
  output logic [ATTR_W-1:0]            win_attr
);
  perm_t p;
  logic  grant;

  always_comb begin
    win = '0;
    for (int i = 0; i < N_RGN; i++) begin
      if (hit[i]) win = IDX_W'(i);
    end
  end

  assign p = perm[win];

  always_comb begin
    if (is_fetch)      grant = (is_priv ? p.pr : p.ur) && !xn[win];
    else if (is_write) grant = is_priv ? p.pw : p.uw;
    else               grant = is_priv ? p.pr : p.ur;
  end

  always_comb begin
    if (!glob_en) begin
      allow    = 1'b1;
      any_hit  = 1'b0;
      win_attr = DEFAULT_ATTR;
    end else if (|hit) begin
      allow    = grant;
      any_hit  = 1'b1;
      win_attr = attr[win];
    end else begin
      allow    = is_priv && bg_en;
      any_hit  = 1'b0;
      win_attr = DEFAULT_ATTR;
    end
  end
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mg_pkg::*;
#(
  parameter int N_RGN  = 8,
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 6,
  parameter int ATTR_W = 6,
  parameter logic [ATTR_W-1:0] DEFAULT_ATTR = 6'h01,
  localparam int IDX_W = (N_RGN > 1) ? $clog2(N_RGN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic              req_fetch,
  output logic              resp_valid,
  output logic              resp_allow,
  output logic              resp_hit,
  output logic [IDX_W-1:0]  resp_region,
  output logic [ATTR_W-1:0] resp_attr
);
  logic                         glob_en, bg_en;
  logic [N_RGN-1:0][ADDR_W-1:0] rgn_base, rgn_cfg;
  logic [N_RGN-1:0]             hit_v, xn_v;
  perm_t [N_RGN-1:0]            perm_v;
  logic [N_RGN-1:0][ATTR_W-1:0] attr_v;
  logic                         allow_c, hit_c;
  logic [IDX_W-1:0]             win_c;
  logic [ATTR_W-1:0]            attr_c;
  logic                         fault_clr, fault_valid;
  logic [ADDR_W-1:0]            fault_addr;

  mg_regs #(.N_RGN(N_RGN), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .glob_en(glob_en), .bg_en(bg_en), .rgn_base(rgn_base), .rgn_cfg(rgn_cfg),
    .deny_evt(req_valid && !allow_c), .deny_addr(req_addr),
    .deny_write(req_write), .deny_priv(req_priv), .deny_fetch(req_fetch),
    .fault_clr(fault_clr), .fault_valid(fault_valid), .fault_addr(fault_addr)
  );

  for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
    mg_region #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_rgn (
      .base_w(rgn_base[g]), .cfg_w(rgn_cfg[g]), .addr(req_addr),
      .hit(hit_v[g]), .perm(perm_v[g]), .xn(xn_v[g]), .attr(attr_v[g])
    );
  end

  mg_decide #(.N_RGN(N_RGN), .ATTR_W(ATTR_W), .DEFAULT_ATTR(DEFAULT_ATTR)) u_dec (
    .hit(hit_v), .perm(perm_v), .xn(xn_v), .attr(attr_v),
    .glob_en(glob_en), .bg_en(bg_en),
    .is_write(req_write), .is_priv(req_priv), .is_fetch(req_fetch),
    .allow(allow_c), .any_hit(hit_c), .win(win_c), .win_attr(attr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_allow  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_region <= '0;
      resp_attr   <= '0;
    end else begin
      resp_valid  <= req_valid;
      resp_allow  <= req_valid && allow_c;
      resp_hit    <= req_valid && hit_c;
      resp_region <= req_valid ? win_c : '0;
      resp_attr   <= req_valid ? attr_c : '0;
    end
  end
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_priv,
  input logic              resp_valid,
  input logic              resp_allow,
  input logic              resp_hit,
  input logic              glob_en,
  input logic              fault_clr,
  input logic              fault_valid,
  input logic [ADDR_W-1:0] fault_addr
);
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);

  a_r9_disabled_allows: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !glob_en) |=> (resp_allow && !resp_hit));

  a_r8_unpriv_miss_denied: assert property (@(posedge clk) disable iff (rst)
    (req_valid && glob_en && !req_priv) |=> (resp_hit || !resp_allow));

  a_r11_deny_latched: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_allow) |-> fault_valid);

  a_r11_fault_held: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && !fault_clr) |=> (fault_valid && $stable(fault_addr)));
endmodule

bind mem_guard mem_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_priv(req_priv),
  .resp_valid(resp_valid), .resp_allow(resp_allow), .resp_hit(resp_hit),
  .glob_en(glob_en), .fault_clr(fault_clr), .fault_valid(fault_valid),
  .fault_addr(fault_addr)
);

// File: tb/test_mem_guard.sv
module test_mem_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_priv = 1'b0;
  logic        req_fetch = 1'b0;
  logic        resp_valid, resp_allow, resp_hit;
  logic [2:0]  resp_region;
  logic [5:0]  resp_attr;

  int checks = 0;
  int errors = 0;
  logic        o_valid, o_allow, o_hit;
  logic [2:0]  o_rgn;
  logic [5:0]  o_attr;
  logic [31:0] rdv;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_guard i_mem_guard (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_priv(req_priv), .req_fetch(req_fetch),
    .resp_valid(resp_valid), .resp_allow(resp_allow), .resp_hit(resp_hit),
    .resp_region(resp_region), .resp_attr(resp_attr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk);
    cfg_addr = a;
    @(posedge clk);
    @(negedge clk);
    rdv = cfg_rdata;
  endtask

  task automatic acc(input logic [31:0] a, input logic w, input logic p, input logic f);
    @(negedge clk);
    req_addr = a; req_write = w; req_priv = p; req_fetch = f; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    o_valid = resp_valid; o_allow = resp_allow; o_hit = resp_hit;
    o_rgn = resp_region; o_attr = resp_attr;
  endtask

  // expect allow, hit, region, attr
  task automatic expect_resp(input string req, input logic al, input logic h,
                             input logic [2:0] r, input logic [5:0] at);
    chk({req, " valid"}, 32'(o_valid), 32'd1);
    chk({req, " allow"}, 32'(o_allow), 32'(al));
    chk({req, " hit"}, 32'(o_hit), 32'(h));
    if (h) chk({req, " region"}, 32'(o_rgn), 32'(r));
    chk({req, " attr"}, 32'(o_attr), 32'(at));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 resp_valid", 32'(resp_valid), 0);
    chk("R1 resp_allow", 32'(resp_allow), 0);
    rd(6'd0); chk("R1 ctrl", rdv, 0);
    rd(6'd2); chk("R1 finfo", rdv, 0);
    @(negedge clk);
    chk("R2 idle no valid", 32'(resp_valid), 0);
  endtask

  task automatic t_disabled;
    acc(32'h1234_5678, 1'b1, 1'b0, 1'b0);
    expect_resp("R9 disabled unpriv write", 1'b1, 1'b0, 3'd0, 6'h01);
    acc(32'h0000_0000, 1'b0, 1'b0, 1'b1);
    expect_resp("R9 disabled fetch (R2)", 1'b1, 1'b0, 3'd0, 6'h01);
  endtask

  task automatic t_readback;
    wr(6'd17, 32'h0A0F_000B);
    wr(6'd16, 32'h2000_0001);
    rd(6'd17); chk("R12 cfg0 readback", rdv, 32'h0A0F_000B);
    rd(6'd16); chk("R12 base0 readback", rdv, 32'h2000_0001);
    wr(6'd0, 32'h1);
    rd(6'd0); chk("R12 ctrl readback", rdv, 32'h1);
  endtask

  task automatic t_background;
    acc(32'h5000_0000, 1'b0, 1'b1, 1'b0);
    expect_resp("R8 priv miss no bg", 1'b0, 1'b0, 3'd0, 6'h01);
    acc(32'h5000_0000, 1'b0, 1'b0, 1'b0);
    expect_resp("R8 unpriv miss", 1'b0, 1'b0, 3'd0, 6'h01);
    wr(6'd0, 32'h3);
    acc(32'h5000_0000, 1'b1, 1'b1, 1'b0);
    expect_resp("R8 priv miss bg", 1'b1, 1'b0, 3'd0, 6'h01);
    acc(32'h5000_0000, 1'b0, 1'b0, 1'b0);
    expect_resp("R8 unpriv miss bg", 1'b0, 1'b0, 3'd0, 6'h01);
  endtask

  task automatic t_region;
    acc(32'h2000_0FFC, 1'b1, 1'b0, 1'b0);
    expect_resp("R3 R10 top of 4KB", 1'b1, 1'b1, 3'd0, 6'h0A);
    acc(32'h2000_1000, 1'b0, 1'b0, 1'b0);
    expect_resp("R3 past end", 1'b0, 1'b0, 3'd0, 6'h01);
    acc(32'h1FFF_FFFC, 1'b0, 1'b0, 1'b0);
    expect_resp("R3 below base", 1'b0, 1'b0, 3'd0, 6'h01);
  endtask

  task automatic t_perm;
    wr(6'd19, 32'h0501_0004);
    wr(6'd18, 32'h3000_0001);
    acc(32'h3000_001C, 1'b0, 1'b1, 1'b0);
    expect_resp("R6 priv read ok (R3 32B)", 1'b1, 1'b1, 3'd1, 6'h05);
    acc(32'h3000_001C, 1'b1, 1'b1, 1'b0);
    expect_resp("R6 priv write denied", 1'b0, 1'b1, 3'd1, 6'h05);
    acc(32'h3000_0000, 1'b0, 1'b0, 1'b0);
    expect_resp("R6 unpriv read denied", 1'b0, 1'b1, 3'd1, 6'h05);
    acc(32'h3000_0020, 1'b0, 1'b0, 1'b0);
    expect_resp("R3 32B end", 1'b0, 1'b0, 3'd0, 6'h01);
    wr(6'd19, 32'h0508_0004);
    acc(32'h3000_0004, 1'b1, 1'b0, 1'b0);
    expect_resp("R6 unpriv write ok", 1'b1, 1'b1, 3'd1, 6'h05);
    acc(32'h3000_0004, 1'b0, 1'b0, 1'b0);
    expect_resp("R6 unpriv read only-write", 1'b0, 1'b1, 3'd1, 6'h05);
  endtask

  task automatic t_xn;
    wr(6'd19, 32'h0511_0004);
    acc(32'h3000_0008, 1'b0, 1'b1, 1'b1);
    expect_resp("R7 fetch xn", 1'b0, 1'b1, 3'd1, 6'h05);
    acc(32'h3000_0008, 1'b0, 1'b1, 1'b0);
    expect_resp("R7 read with xn", 1'b1, 1'b1, 3'd1, 6'h05);
    wr(6'd19, 32'h0501_0004);
    acc(32'h3000_0008, 1'b0, 1'b1, 1'b1);
    expect_resp("R7 fetch no xn", 1'b1, 1'b1, 3'd1, 6'h05);
    acc(32'h3000_0008, 1'b0, 1'b0, 1'b1);
    expect_resp("R7 unpriv fetch", 1'b0, 1'b1, 3'd1, 6'h05);
  endtask

  task automatic t_subregion;
    wr(6'd17, 32'h0A0F_080B);
    acc(32'h2000_0600, 1'b0, 1'b0, 1'b0);
    expect_resp("R4 disabled eighth", 1'b0, 1'b0, 3'd0, 6'h01);
    acc(32'h2000_0800, 1'b0, 1'b0, 1'b0);
    expect_resp("R4 next eighth", 1'b1, 1'b1, 3'd0, 6'h0A);
    acc(32'h2000_05FC, 1'b0, 1'b0, 1'b0);
    expect_resp("R4 prior eighth", 1'b1, 1'b1, 3'd0, 6'h0A);
  endtask

  task automatic t_overlap;
    wr(6'd21, 32'h1501_0009);
    wr(6'd20, 32'h2000_0001);
    acc(32'h2000_0100, 1'b0, 1'b0, 1'b0);
    expect_resp("R5 higher wins deny", 1'b0, 1'b1, 3'd2, 6'h15);
    acc(32'h2000_0100, 1'b0, 1'b1, 1'b0);
    expect_resp("R5 R10 higher wins priv", 1'b1, 1'b1, 3'd2, 6'h15);
    acc(32'h2000_0500, 1'b0, 1'b0, 1'b0);
    expect_resp("R5 outside inner", 1'b1, 1'b1, 3'd0, 6'h0A);
    wr(6'd20, 32'h2000_0000);
    acc(32'h2000_0100, 1'b0, 1'b0, 1'b0);
    expect_resp("R5 inner disabled", 1'b1, 1'b1, 3'd0, 6'h0A);
    wr(6'd23, 32'h3F0F_001F);
    wr(6'd22, 32'h0000_0001);
    acc(32'hFFFF_FFF0, 1'b1, 1'b0, 1'b0);
    expect_resp("R3 4GB region", 1'b1, 1'b1, 3'd3, 6'h3F);
    acc(32'h2000_0100, 1'b0, 1'b0, 1'b0);
    expect_resp("R5 4GB over region0", 1'b1, 1'b1, 3'd3, 6'h3F);
    wr(6'd22, 32'h0);
  endtask

  task automatic t_fault;
    wr(6'd2, 32'h1);
    rd(6'd2); chk("R11 cleared info", rdv, 0);
    wr(6'd19, 32'h0501_0004);
    acc(32'h3000_0004, 1'b1, 1'b0, 1'b0);
    expect_resp("R11 deny source", 1'b0, 1'b1, 3'd1, 6'h05);
    rd(6'd1); chk("R11 fault addr", rdv, 32'h3000_0004);
    rd(6'd2); chk("R11 fault info", rdv, 32'h3);
    acc(32'h7000_0000, 1'b0, 1'b0, 1'b0);
    rd(6'd1); chk("R11 addr held", rdv, 32'h3000_0004);
    rd(6'd2); chk("R11 info held", rdv, 32'h3);
    wr(6'd2, 32'h1);
    rd(6'd2); chk("R11 clear info", rdv, 0);
    rd(6'd1); chk("R11 clear addr", rdv, 0);
    acc(32'h3000_0000, 1'b1, 1'b1, 1'b0);
    rd(6'd2); chk("R11 priv write info", rdv, 32'h7);
    rd(6'd1); chk("R11 new addr", rdv, 32'h3000_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_readback();
    t_background();
    t_region();
    t_perm();
    t_xn();
    t_subregion();
    t_overlap();
    t_fault();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule